// File: doc/BRIEF.md
# 64-bit Shift and Rotate Unit

This execution unit takes one operation per cycle on a 64-bit integer datapath and returns a registered result on the following cycle. It rotates left, shifts left, shifts right arithmetically and shifts right logically across the full 64-bit operand. Two word forms act on the low 32 bits of the operand and widen the answer to 64 bits by copying bit 31: a left shift, and a logical right shift.

The shift amount comes either from a second register operand or from a 6-bit immediate field. A select input picks the source. An operation code picks the function. Unused codes raise a flag for one cycle and produce a zero result.

Top module: `shift_rot_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `illegal` and `result` are cleared to zero.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. When `in_valid` is low, `result` keeps its previous value and `illegal` is low in the next cycle.
- R3: The shift amount is `imm` when `use_imm` is 1. Otherwise it is bits 5:0 of `opnd_b`, and bits 63:6 of `opnd_b` have no effect.
- R4: Code 0 rotates `opnd_a` left by the amount modulo 64. Bits leaving bit 63 re-enter at bit 0.
- R5: Code 1 shifts `opnd_a` left by the amount and fills the vacated low bits with zeros.
- R6: Code 2 shifts `opnd_a` right by the amount and fills the vacated high bits with bit 63 of `opnd_a`.
- R7: Code 3 shifts `opnd_a` right by the amount and fills the vacated high bits with zeros.
- R8: Code 4 shifts `opnd_a` left by bits 4:0 of the amount. Bits 63:32 of the result are copies of bit 31 of the shifted value.
- R9: Code 5 shifts bits 31:0 of `opnd_a`, zero-extended, right by bits 4:0 of the amount, then sign-extends the result from bit 31. An amount of zero in those bits gives `opnd_a[31:0]` sign-extended. A nonzero amount gives zeros in bits 63:32.
- R10: Codes 6 and 7 set `illegal` high for one cycle together with `out_valid`, and set `result` to zero. Codes 0 to 5 leave `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (0 to 7) |
| opnd_a | input | 64 | Value to be shifted or rotated |
| opnd_b | input | 64 | Register source of the shift amount |
| imm | input | 6 | Immediate shift amount |
| use_imm | input | 1 | 1 selects `imm` as the amount, 0 selects `opnd_b` |
| out_valid | output | 1 | Result present this cycle |
| result | output | 64 | Registered result |
| illegal | output | 1 | The operation code was 6 or 7 |

## Verification
The properties assume that `op`, `use_imm`, `imm` and `opnd_b` hold known values whenever `in_valid` is high. The amount-dependent checks compute the amount from those ports in the same cycle. The bench drives every input on the falling edge, so each value is stable around the rising edge that captures it. The bench never leaves an X on an input while `in_valid` is high, and it tests the gap behaviour only after a valid operation has left a known value in `result`.

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int W = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [2:0]             op,
  input  logic [W-1:0]           opnd_a,
  input  logic [W-1:0]           opnd_b,
  input  logic [$clog2(W)-1:0]   imm,
  input  logic                   use_imm,
  output logic                   out_valid,
  output logic [W-1:0]           result,
  output logic                   illegal
);
  localparam int H  = W / 2;
  localparam int AW = $clog2(W);

  localparam logic [2:0] OP_ROTL  = 3'd0;
  localparam logic [2:0] OP_SHL   = 3'd1;
  localparam logic [2:0] OP_SHRS  = 3'd2;
  localparam logic [2:0] OP_SHRU  = 3'd3;
  localparam logic [2:0] OP_SHLW  = 3'd4;
  localparam logic [2:0] OP_SHRUW = 3'd5;

  logic [AW-1:0]  amt;
  logic [AW-2:0]  amt_w;
  logic [2*W-1:0] rot_ext;
  logic [W-1:0]   rot_v, shl_v, shrs_v, shru_v;
  logic [H-1:0]   shlw_lo, shruw_lo;
  logic [W-1:0]   nxt;
  logic           bad;

  assign amt     = use_imm ? imm : opnd_b[AW-1:0];
  assign amt_w   = amt[AW-2:0];

  assign rot_ext = {opnd_a, opnd_a} << amt;
  assign rot_v   = rot_ext[2*W-1:W];
  assign shl_v   = opnd_a << amt;
  assign shrs_v  = $unsigned($signed(opnd_a) >>> amt);
  assign shru_v  = opnd_a >> amt;
  assign shlw_lo = opnd_a[H-1:0] << amt_w;
  assign shruw_lo = opnd_a[H-1:0] >> amt_w;

  always_comb begin
    nxt = '0;
    bad = 1'b0;
    case (op)
      OP_ROTL:  nxt = rot_v;
      OP_SHL:   nxt = shl_v;
      OP_SHRS:  nxt = shrs_v;
      OP_SHRU:  nxt = shru_v;
      OP_SHLW:  nxt = {{H{shlw_lo[H-1]}}, shlw_lo};
      OP_SHRUW: nxt = {{H{shruw_lo[H-1]}}, shruw_lo};
      default:  bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid & bad;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/shift_rot_unit_chk.sv
module shift_rot_unit_chk #(
  parameter int W = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [2:0]           op,
  input logic [W-1:0]         opnd_a,
  input logic [W-1:0]         opnd_b,
  input logic [$clog2(W)-1:0] imm,
  input logic                 use_imm,
  input logic                 out_valid,
  input logic [W-1:0]         result,
  input logic                 illegal
);
  localparam int H = W / 2;
  localparam int AW = $clog2(W);

  logic [AW-1:0] chk_amt;
  assign chk_amt = use_imm ? imm : opnd_b[AW-1:0];

  always @(negedge clk) begin
    if (rst) begin
      p_reset_clear_r1: assert (!out_valid && !illegal && result == '0)
        else $error("reset did not clear outputs");
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !illegal));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  p_shl_zero_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd1 && chk_amt != '0) |=> !result[0]);
  p_word_left_sext_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd4) |=> result[W-1:H] == {H{result[H-1]}});
  p_word_right_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd5 && chk_amt[AW-2:0] != '0) |=> result[W-1:H] == '0);
  p_word_right_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd5 && chk_amt[AW-2:0] == '0) |=>
      result == {{H{$past(opnd_a[H-1])}}, $past(opnd_a[H-1:0])});
  p_illegal_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[2:1] == 2'b11) |=> (illegal && out_valid && result == '0));
  p_legal_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[2:1] != 2'b11) |=> !illegal);
endmodule

bind shift_rot_unit shift_rot_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opnd_a(opnd_a),
  .opnd_b(opnd_b), .imm(imm), .use_imm(use_imm), .out_valid(out_valid),
  .result(result), .illegal(illegal)
);

// File: tb/shift_rot_unit_test.sv
module shift_rot_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [5:0]  imm = '0;
  logic        use_imm = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  logic [63:0] exp_res_q[$];
  logic        exp_ill_q[$];
  string       exp_tag_q[$];

  always #2.5 clk = ~clk;

  shift_rot_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .imm(imm), .use_imm(use_imm), .out_valid(out_valid),
    .result(result), .illegal(illegal)
  );

  function automatic logic [64:0] model(input logic [2:0] o, input logic [63:0] a,
                                        input logic [63:0] b, input logic [5:0] im,
                                        input logic ui);
    logic [5:0]  n;
    logic [63:0] r;
    logic [31:0] w;
    n = ui ? im : b[5:0];
    r = a;
    case (o)
      3'd0: for (int i = 0; i < int'(n); i++) r = {r[62:0], r[63]};
      3'd1: for (int i = 0; i < int'(n); i++) r = {r[62:0], 1'b0};
      3'd2: for (int i = 0; i < int'(n); i++) r = {r[63], r[63:1]};
      3'd3: for (int i = 0; i < int'(n); i++) r = {1'b0, r[63:1]};
      3'd4: begin
        w = a[31:0];
        for (int i = 0; i < int'(n[4:0]); i++) w = {w[30:0], 1'b0};
        r = {{32{w[31]}}, w};
      end
      3'd5: begin
        w = a[31:0];
        for (int i = 0; i < int'(n[4:0]); i++) w = {1'b0, w[31:1]};
        r = {{32{w[31]}}, w};
      end
      default: return {1'b1, 64'd0};
    endcase
    return {1'b0, r};
  endfunction

  task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [2:0] o, input logic [63:0] a,
                       input logic [63:0] b, input logic [5:0] im, input logic ui);
    logic [64:0] m;
    m = model(o, a, b, im, ui);
    exp_res_q.push_back(m[63:0]);
    exp_ill_q.push_back(m[64]);
    exp_tag_q.push_back(tag);
    in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b; imm = im; use_imm = ui;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_res_q.size() == 0) begin
        check("R2 unexpected valid", 65'd1, 65'd0);
      end else begin
        check(exp_tag_q.pop_front(), {illegal, result},
              {exp_ill_q.pop_front(), exp_res_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset state", {out_valid, illegal, result}, 65'd0);
    rst = 1'b0;
    @(negedge clk);

    // R4 rotate
    drive("R4 rotl 4",   3'd0, 64'hF000_0000_0000_000F, 64'd4, 6'd0, 1'b0);
    drive("R4 rotl 63",  3'd0, 64'h8000_0000_0000_0001, 64'd63, 6'd0, 1'b0);
    drive("R4 rotl 0",   3'd0, 64'h0123_4567_89AB_CDEF, 64'd0, 6'd0, 1'b0);
    // R3 upper bits of B ignored, immediate path
    drive("R3 b upper",  3'd0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FF48, 6'd0, 1'b0);
    drive("R3 imm sel",  3'd1, 64'h0000_0000_0000_00FF, 64'd1, 6'd36, 1'b1);
    // R5 shl
    drive("R5 shl 8",    3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd8, 6'd0, 1'b0);
    drive("R5 shl 63",   3'd1, 64'h0000_0000_0000_0003, 64'd63, 6'd0, 1'b0);
    // R6 arithmetic right
    drive("R6 shrs neg", 3'd2, 64'h8000_0000_0000_0000, 64'd12, 6'd0, 1'b0);
    drive("R6 shrs pos", 3'd2, 64'h7000_0000_0000_0000, 6'd0, 6'd60, 1'b1);
    // R7 logical right
    drive("R7 shru",     3'd3, 64'h8000_0000_0000_0000, 64'd63, 6'd0, 1'b0);
    drive("R7 shru imm", 3'd3, 64'hFFFF_0000_FFFF_0000, 64'd0, 6'd20, 1'b1);
    // R8 word left: bit 5 of amount dropped
    drive("R8 shlw",     3'd4, 64'hAAAA_AAAA_0000_0001, 64'd31, 6'd0, 1'b0);
    drive("R8 shlw 32",  3'd4, 64'h0000_0000_1234_5678, 64'd32, 6'd0, 1'b0);
    drive("R8 shlw imm", 3'd4, 64'h0000_0000_0000_0001, 64'd0, 6'd33, 1'b1);
    // R9 word logical right
    drive("R9 shruw 0",  3'd5, 64'h1234_5678_8000_0001, 64'd0, 6'd0, 1'b0);
    drive("R9 shruw 32", 3'd5, 64'h0000_0000_F000_0000, 64'd0, 6'd32, 1'b1);
    drive("R9 shruw 1",  3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 6'd0, 1'b0);
    // R10 illegal codes
    drive("R10 code 6",  3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 6'd0, 1'b0);
    drive("R10 code 7",  3'd7, 64'h1, 64'd1, 6'd5, 1'b1);
    drive("R10 legal after", 3'd3, 64'h100, 64'd4, 6'd0, 1'b0);

    // R2 hold across an idle gap
    @(negedge clk);
    held = result;
    in_valid = 1'b0; op = 3'd1; opnd_a = '1; opnd_b = 64'd3;
    @(negedge clk);
    check("R2 idle valid", {out_valid, illegal}, 65'd0);
    check("R2 idle hold", {1'b0, result}, {1'b0, held});

    repeat (3) @(negedge clk);
    check("R2 queue drained", 65'(exp_res_q.size()), 65'd0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule